// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state changes a processor core makes when it takes a trap. A trap request brings a 6-bit major cause code, a 9-bit sub-code, the faulting program counter, the faulting instruction word and a flag saying whether the fault needs the TLB-refill handler. A failed bus transaction can raise a trap by itself and is turned into an address-error cause. On the clock edge that accepts a request, the block moves the current mode into the matching saved-mode register, captures the return address, the bad address and the bad instruction where the cause requires it, drops to privilege level 0 with interrupts disabled, and issues a one-cycle redirect to the handler address.

There are three entry paths. The ordinary path covers exceptions and interrupts. The refill path handles TLB misses. The debug path handles breakpoints, and it also takes any interrupt that arrives while the core is already in debug state. Each path has its own saved state and its own target. Ordinary handlers sit at a programmable power-of-two spacing from a shared base. Interrupt handlers start 64 slots above that base. A neighbouring return unit reloads the current mode through a small load port; this block does not decode the return instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: Reset gives redirect_pc = 0x1C000000, cur_plv = 0, cur_ie = 0, cur_da = 1, cur_pg = 0, refill_busy = 0, dbg_dst = 0 and redirect_valid = 0.
- R2: A request (trap_valid, or bus_fail_valid) makes redirect_valid high for exactly the following cycle. That cycle also shows cur_plv = 0 and cur_ie = 0, whatever the path. Without a request, redirect_valid stays low.
- R3: On the ordinary path, exc_code and exc_subcode take the cause, save_plv and save_ie take the previous current mode, and era takes trap_pc.
- R4: A non-interrupt, non-breakpoint trap with trap_refill = 1 takes the refill path. rf_save_plv and rf_save_ie take the previous mode, cur_da becomes 1 and cur_pg becomes 0, rf_era becomes trap_pc >> 2, refill_busy becomes 1, and redirect_pc becomes cfg_refill_entry. On this path era, save_plv/save_ie and exc_code keep their values.
- R5: For an ordinary exception the target is cfg_eentry when cfg_vs = 0. Otherwise it is cfg_eentry + code * (4 << cfg_vs).
- R6: An interrupt (code 0) targets cfg_eentry + (64 + n) * spacing, where n is the highest set bit of irq_lines (0 if none is set). trap_refill is ignored for interrupts, and badi is not changed.
- R7: badv takes trap_pc for causes 11, 12, 13, 14, 15, 16, 17 and 18. It keeps its value for every other cause.
- R8: badi takes trap_insn for every cause except interrupts (code 0), fetch page-invalid (code 3) and fetch address error (code 8 with sub-code 0).
- R9: A breakpoint (code 26) sets dbg_dcl = 1, dbg_code = 0xC, dbg_era = trap_pc and dbg_dst = 1, and targets cfg_eentry + 0x480.
- R10: An interrupt taken while dbg_dst = 1 sets dbg_dei = 1, writes dbg_era and targets cfg_eentry + 0x480. It leaves era and exc_code unchanged and does not set dbg_dcl.
- R11: With trap_valid low, a failed bus transaction is taken as code 8 on the ordinary path. The sub-code is 0 when bus_fail_fetch = 1 (no badi capture) and 1 otherwise (badi captured). trap_valid has priority over bus_fail_valid.
- R12: mode_ld_valid loads cur_plv, cur_ie and cur_pg, sets cur_da = !mode_ld_pg, and clears refill_busy. With mode_ld_dbg_exit = 1 it also clears dbg_dst, dbg_dcl and dbg_dei. A request in the same cycle wins over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request |
| trap_code | input | 6 | Major cause code |
| trap_sub | input | 9 | Cause sub-code |
| trap_pc | input | PC_W | Faulting program counter |
| trap_insn | input | INSN_W | Faulting instruction word |
| trap_refill | input | 1 | Fault needs the refill handler |
| irq_lines | input | IRQ_N | Pending, unmasked interrupt lines |
| bus_fail_valid | input | 1 | Failed bus transaction |
| bus_fail_fetch | input | 1 | Failed transaction was a fetch |
| mode_ld_valid | input | 1 | Load current mode (return path) |
| mode_ld_plv | input | 2 | Privilege level to load |
| mode_ld_ie | input | 1 | Interrupt enable to load |
| mode_ld_pg | input | 1 | Paging to load (direct mode is its inverse) |
| mode_ld_dbg_exit | input | 1 | Leave debug state on the load |
| cfg_vs | input | VS_W | Vector spacing exponent |
| cfg_eentry | input | PC_W | Ordinary and debug entry base |
| cfg_refill_entry | input | PC_W | Refill handler address |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | PC_W | Handler address |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Current interrupt enable |
| cur_da | output | 1 | Direct-address mode |
| cur_pg | output | 1 | Paging enabled |
| save_plv | output | 2 | Ordinary saved privilege |
| save_ie | output | 1 | Ordinary saved interrupt enable |
| rf_save_plv | output | 2 | Refill saved privilege |
| rf_save_ie | output | 1 | Refill saved interrupt enable |
| refill_busy | output | 1 | Refill handler in progress |
| exc_code | output | 6 | Recorded major code |
| exc_subcode | output | 9 | Recorded sub-code |
| era | output | PC_W | Ordinary return address |
| rf_era | output | PC_W | Refill return address (word index) |
| dbg_era | output | PC_W | Debug return address |
| badv | output | PC_W | Bad address |
| badi | output | INSN_W | Bad instruction |
| dbg_dst | output | 1 | Debug state |
| dbg_dcl | output | 1 | Debug entered by breakpoint |
| dbg_dei | output | 1 | Debug entered by interrupt |
| dbg_code | output | 6 | Debug exception code |

## Verification
A wrong route choice shows in the cycle after the request. The redirect address lands on the wrong base, or a return register that should have held its value changes (era on refill, era on an interrupt in debug state). A mistake in the capture conditions shows at once in badv or badi, compared against the values read just before the trap. A mode bit that is saved or cleared wrongly shows up as a wrong saved privilege on the next trap, or as a refill-busy or debug flag that survives the mode load meant to clear it. The bench therefore sets a non-zero mode before every trap, and it reads the outputs before and after each trap.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int CODE_W = 6;
    localparam int SUB_W  = 9;
    localparam int PLV_W  = 2;

    localparam logic [CODE_W-1:0] EC_INT  = 6'd0;
    localparam logic [CODE_W-1:0] EC_PIF  = 6'd3;
    localparam logic [CODE_W-1:0] EC_ADE  = 6'd8;
    localparam logic [CODE_W-1:0] EC_SYS  = 6'd11;
    localparam logic [CODE_W-1:0] EC_BRK  = 6'd12;
    localparam logic [CODE_W-1:0] EC_INE  = 6'd13;
    localparam logic [CODE_W-1:0] EC_IPE  = 6'd14;
    localparam logic [CODE_W-1:0] EC_FPD  = 6'd15;
    localparam logic [CODE_W-1:0] EC_SXD  = 6'd16;
    localparam logic [CODE_W-1:0] EC_ASXD = 6'd17;
    localparam logic [CODE_W-1:0] EC_FPE  = 6'd18;
    localparam logic [CODE_W-1:0] EC_DBP  = 6'd26;

    localparam logic [SUB_W-1:0] SUB_FETCH = 9'd0;
    localparam logic [SUB_W-1:0] SUB_MEM   = 9'd1;

    localparam logic [CODE_W-1:0] DBG_BP_CODE  = 6'hC;
    localparam int                INT_VEC_BASE = 64;
    localparam int                DBG_OFFSET   = 32'h480;

    typedef enum logic [1:0] {
        PATH_NORMAL = 2'd0,
        PATH_REFILL = 2'd1,
        PATH_DEBUG  = 2'd2
    } path_e;

    typedef struct packed {
        path_e path;
        logic  is_int;
        logic  dbg_int;
        logic  set_badv;
        logic  set_badi;
    } route_t;

    typedef struct packed {
        logic [PLV_W-1:0] plv;
        logic             ie;
        logic             da;
        logic             pg;
    } mode_t;

    function automatic logic code_captures_pc(input logic [CODE_W-1:0] c);
        case (c)
            EC_SYS, EC_BRK, EC_INE, EC_IPE,
            EC_FPD, EC_SXD, EC_ASXD, EC_FPE: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic code_captures_insn(input logic [CODE_W-1:0] c,
                                                input logic [SUB_W-1:0]  s);
        if (c == EC_INT || c == EC_PIF)
            return 1'b0;
        if (c == EC_ADE && s == SUB_FETCH)
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/exc_route_decode.sv
module exc_route_decode
    import exc_seq_pkg::*;
(
    input  logic              trap_valid,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [SUB_W-1:0]  trap_sub,
    input  logic              trap_refill,
    input  logic              bus_fail_valid,
    input  logic              bus_fail_fetch,
    input  logic              dbg_active,
    output logic              take,
    output logic [CODE_W-1:0] eff_code,
    output logic [SUB_W-1:0]  eff_sub,
    output route_t            route
);
    logic is_int;
    logic is_bp;

    always_comb begin
        take = trap_valid | bus_fail_valid;
        if (trap_valid) begin
            eff_code = trap_code;
            eff_sub  = trap_sub;
        end else begin
            eff_code = EC_ADE;
            eff_sub  = bus_fail_fetch ? SUB_FETCH : SUB_MEM;
        end
        is_int = trap_valid && (trap_code == EC_INT);
        is_bp  = trap_valid && (trap_code == EC_DBP);

        route.is_int  = is_int;
        route.dbg_int = is_int && dbg_active;
        if (is_bp || route.dbg_int)
            route.path = PATH_DEBUG;
        else if (trap_valid && trap_refill && !is_int)
            route.path = PATH_REFILL;
        else
            route.path = PATH_NORMAL;
        route.set_badv = code_captures_pc(eff_code);
        route.set_badi = code_captures_insn(eff_code, eff_sub);
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_seq_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IRQ_N = 13,
    parameter int VS_W  = 3
) (
    input  route_t            route,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [IRQ_N-1:0]  irq_lines,
    input  logic [VS_W-1:0]   cfg_vs,
    input  logic [PC_W-1:0]   cfg_eentry,
    input  logic [PC_W-1:0]   cfg_refill_entry,
    output logic [PC_W-1:0]   target_pc
);
    localparam int LINE_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;
    localparam int VNUM_W = $clog2(INT_VEC_BASE + IRQ_N + 1);
    localparam int SH_W   = VS_W + 1;

    logic [LINE_W-1:0] win_line;
    logic [VNUM_W-1:0] vec_num;
    logic [SH_W-1:0]   shamt;
    logic [PC_W-1:0]   offset;

    always_comb begin
        win_line = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            if (irq_lines[i])
                win_line = LINE_W'(i);
        end
    end

    always_comb begin
        if (route.is_int)
            vec_num = VNUM_W'(INT_VEC_BASE) + VNUM_W'(win_line);
        else
            vec_num = VNUM_W'(eff_code);
        shamt = SH_W'(cfg_vs) + SH_W'(2);
        if (cfg_vs == '0)
            offset = '0;
        else
            offset = PC_W'(vec_num) << shamt;

        case (route.path)
            PATH_DEBUG:  target_pc = cfg_eentry + PC_W'(DBG_OFFSET);
            PATH_REFILL: target_pc = cfg_refill_entry;
            default:     target_pc = cfg_eentry + offset;
        endcase
    end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_seq_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              INSN_W   = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h1C00_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  route_t            route,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [SUB_W-1:0]  eff_sub,
    input  logic [PC_W-1:0]   trap_pc,
    input  logic [INSN_W-1:0] trap_insn,
    input  logic [PC_W-1:0]   target_pc,
    input  logic              mode_ld_valid,
    input  logic [PLV_W-1:0]  mode_ld_plv,
    input  logic              mode_ld_ie,
    input  logic              mode_ld_pg,
    input  logic              mode_ld_dbg_exit,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output mode_t             cur,
    output logic [PLV_W-1:0]  save_plv,
    output logic              save_ie,
    output logic [PLV_W-1:0]  rf_save_plv,
    output logic              rf_save_ie,
    output logic              refill_busy,
    output logic [CODE_W-1:0] exc_code,
    output logic [SUB_W-1:0]  exc_subcode,
    output logic [PC_W-1:0]   era,
    output logic [PC_W-1:0]   rf_era,
    output logic [PC_W-1:0]   dbg_era,
    output logic [PC_W-1:0]   badv,
    output logic [INSN_W-1:0] badi,
    output logic              dbg_dst,
    output logic              dbg_dcl,
    output logic              dbg_dei,
    output logic [CODE_W-1:0] dbg_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= RESET_PC;
            cur            <= '{plv: '0, ie: 1'b0, da: 1'b1, pg: 1'b0};
            save_plv       <= '0;
            save_ie        <= 1'b0;
            rf_save_plv    <= '0;
            rf_save_ie     <= 1'b0;
            refill_busy    <= 1'b0;
            exc_code       <= '0;
            exc_subcode    <= '0;
            era            <= '0;
            rf_era         <= '0;
            dbg_era        <= '0;
            badv           <= '0;
            badi           <= '0;
            dbg_dst        <= 1'b0;
            dbg_dcl        <= 1'b0;
            dbg_dei        <= 1'b0;
            dbg_code       <= '0;
        end else begin
            redirect_valid <= take;
            if (take) begin
                redirect_pc <= target_pc;
                cur.plv     <= '0;
                cur.ie      <= 1'b0;
                case (route.path)
                    PATH_REFILL: begin
                        rf_save_plv <= cur.plv;
                        rf_save_ie  <= cur.ie;
                        cur.da      <= 1'b1;
                        cur.pg      <= 1'b0;
                        rf_era      <= trap_pc >> 2;
                        refill_busy <= 1'b1;
                    end
                    PATH_DEBUG: begin
                        dbg_era <= trap_pc;
                        dbg_dst <= 1'b1;
                        if (route.dbg_int) begin
                            dbg_dei <= 1'b1;
                        end else begin
                            dbg_dcl  <= 1'b1;
                            dbg_code <= DBG_BP_CODE;
                        end
                    end
                    default: begin
                        exc_code    <= eff_code;
                        exc_subcode <= eff_sub;
                        save_plv    <= cur.plv;
                        save_ie     <= cur.ie;
                        era         <= trap_pc;
                    end
                endcase
                if (route.set_badv && route.path != PATH_DEBUG)
                    badv <= trap_pc;
                if (route.set_badi)
                    badi <= trap_insn;
            end else if (mode_ld_valid) begin
                cur.plv     <= mode_ld_plv;
                cur.ie      <= mode_ld_ie;
                cur.pg      <= mode_ld_pg;
                cur.da      <= ~mode_ld_pg;
                refill_busy <= 1'b0;
                if (mode_ld_dbg_exit) begin
                    dbg_dst <= 1'b0;
                    dbg_dcl <= 1'b0;
                    dbg_dei <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32,
    parameter int IRQ_N  = 13,
    parameter int VS_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_valid,
    input  logic [5:0]        trap_code,
    input  logic [8:0]        trap_sub,
    input  logic [PC_W-1:0]   trap_pc,
    input  logic [INSN_W-1:0] trap_insn,
    input  logic              trap_refill,
    input  logic [IRQ_N-1:0]  irq_lines,
    input  logic              bus_fail_valid,
    input  logic              bus_fail_fetch,
    input  logic              mode_ld_valid,
    input  logic [1:0]        mode_ld_plv,
    input  logic              mode_ld_ie,
    input  logic              mode_ld_pg,
    input  logic              mode_ld_dbg_exit,
    input  logic [VS_W-1:0]   cfg_vs,
    input  logic [PC_W-1:0]   cfg_eentry,
    input  logic [PC_W-1:0]   cfg_refill_entry,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [1:0]        cur_plv,
    output logic              cur_ie,
    output logic              cur_da,
    output logic              cur_pg,
    output logic [1:0]        save_plv,
    output logic              save_ie,
    output logic [1:0]        rf_save_plv,
    output logic              rf_save_ie,
    output logic              refill_busy,
    output logic [5:0]        exc_code,
    output logic [8:0]        exc_subcode,
    output logic [PC_W-1:0]   era,
    output logic [PC_W-1:0]   rf_era,
    output logic [PC_W-1:0]   dbg_era,
    output logic [PC_W-1:0]   badv,
    output logic [INSN_W-1:0] badi,
    output logic              dbg_dst,
    output logic              dbg_dcl,
    output logic              dbg_dei,
    output logic [5:0]        dbg_code
);
    logic              take;
    logic [CODE_W-1:0] eff_code;
    logic [SUB_W-1:0]  eff_sub;
    route_t            route;
    logic [PC_W-1:0]   target_pc;
    mode_t             cur;

    exc_route_decode u_decode (
        .trap_valid     (trap_valid),
        .trap_code      (trap_code),
        .trap_sub       (trap_sub),
        .trap_refill    (trap_refill),
        .bus_fail_valid (bus_fail_valid),
        .bus_fail_fetch (bus_fail_fetch),
        .dbg_active     (dbg_dst),
        .take           (take),
        .eff_code       (eff_code),
        .eff_sub        (eff_sub),
        .route          (route)
    );

    exc_vector_gen #(
        .PC_W  (PC_W),
        .IRQ_N (IRQ_N),
        .VS_W  (VS_W)
    ) u_vector (
        .route            (route),
        .eff_code         (eff_code),
        .irq_lines        (irq_lines),
        .cfg_vs           (cfg_vs),
        .cfg_eentry       (cfg_eentry),
        .cfg_refill_entry (cfg_refill_entry),
        .target_pc        (target_pc)
    );

    exc_csr_bank #(
        .PC_W   (PC_W),
        .INSN_W (INSN_W)
    ) u_bank (
        .clk              (clk),
        .rst              (rst),
        .take             (take),
        .route            (route),
        .eff_code         (eff_code),
        .eff_sub          (eff_sub),
        .trap_pc          (trap_pc),
        .trap_insn        (trap_insn),
        .target_pc        (target_pc),
        .mode_ld_valid    (mode_ld_valid),
        .mode_ld_plv      (mode_ld_plv),
        .mode_ld_ie       (mode_ld_ie),
        .mode_ld_pg       (mode_ld_pg),
        .mode_ld_dbg_exit (mode_ld_dbg_exit),
        .redirect_valid   (redirect_valid),
        .redirect_pc      (redirect_pc),
        .cur              (cur),
        .save_plv         (save_plv),
        .save_ie          (save_ie),
        .rf_save_plv      (rf_save_plv),
        .rf_save_ie       (rf_save_ie),
        .refill_busy      (refill_busy),
        .exc_code         (exc_code),
        .exc_subcode      (exc_subcode),
        .era              (era),
        .rf_era           (rf_era),
        .dbg_era          (dbg_era),
        .badv             (badv),
        .badi             (badi),
        .dbg_dst          (dbg_dst),
        .dbg_dcl          (dbg_dcl),
        .dbg_dei          (dbg_dei),
        .dbg_code         (dbg_code)
    );

    assign cur_plv = cur.plv;
    assign cur_ie  = cur.ie;
    assign cur_da  = cur.da;
    assign cur_pg  = cur.pg;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic [5:0]      trap_code,
    input logic            trap_refill,
    input logic            bus_fail_valid,
    input logic            bus_fail_fetch,
    input logic [PC_W-1:0] cfg_eentry,
    input logic [PC_W-1:0] cfg_refill_entry,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic [1:0]      cur_plv,
    input logic            cur_ie,
    input logic            cur_da,
    input logic            cur_pg,
    input logic [5:0]      exc_code,
    input logic [8:0]      exc_subcode,
    input logic [PC_W-1:0] era,
    input logic            dbg_dst,
    input logic            dbg_dei
);
    logic take;
    logic refill_take;
    assign take        = trap_valid | bus_fail_valid;
    assign refill_take = trap_valid && trap_refill && trap_code != 6'd0 && trap_code != 6'd26;

    AST_ENTRY_DROPS_MODE: assert property (@(posedge clk) disable iff (rst)
        take |=> redirect_valid && cur_plv == 2'd0 && !cur_ie); // R2
    AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        !take |=> !redirect_valid); // R2
    AST_REFILL_TARGET: assert property (@(posedge clk) disable iff (rst)
        refill_take |=> cur_da && !cur_pg && redirect_pc == $past(cfg_refill_entry)); // R4
    AST_REFILL_KEEPS_ERA: assert property (@(posedge clk) disable iff (rst)
        refill_take |=> $stable(era)); // R4
    AST_BREAK_TARGET: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_code == 6'd26) |=> dbg_dst && redirect_pc == $past(cfg_eentry) + 32'h480); // R9
    AST_DEBUG_INT: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_code == 6'd0 && dbg_dst) |=> dbg_dei && $stable(era)); // R10
    AST_BUS_FAIL_CODE: assert property (@(posedge clk) disable iff (rst)
        (!trap_valid && bus_fail_valid) |=> exc_code == 6'd8 && exc_subcode == {8'd0, !$past(bus_fail_fetch)}); // R11
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .trap_valid       (trap_valid),
    .trap_code        (trap_code),
    .trap_refill      (trap_refill),
    .bus_fail_valid   (bus_fail_valid),
    .bus_fail_fetch   (bus_fail_fetch),
    .cfg_eentry       (cfg_eentry),
    .cfg_refill_entry (cfg_refill_entry),
    .redirect_valid   (redirect_valid),
    .redirect_pc      (redirect_pc),
    .cur_plv          (cur_plv),
    .cur_ie           (cur_ie),
    .cur_da           (cur_da),
    .cur_pg           (cur_pg),
    .exc_code         (exc_code),
    .exc_subcode      (exc_subcode),
    .era              (era),
    .dbg_dst          (dbg_dst),
    .dbg_dei          (dbg_dei)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam logic [31:0] EBASE = 32'h0000_8000;
    localparam logic [31:0] RBASE = 32'h0000_F000;

    typedef struct packed {
        logic [2:0]  vs;
        logic [5:0]  code;
        logic [8:0]  sub;
        logic        refill;
        logic [12:0] lines;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{3'd0, 6'd11, 9'd0, 1'b0, 13'h0000},
        '{3'd1, 6'd11, 9'd0, 1'b0, 13'h0000},
        '{3'd3, 6'd3,  9'd0, 1'b0, 13'h0000},
        '{3'd2, 6'd0,  9'd0, 1'b0, 13'h0090},
        '{3'd1, 6'd1,  9'd0, 1'b1, 13'h0000},
        '{3'd7, 6'd8,  9'd1, 1'b0, 13'h0000},
        '{3'd2, 6'd18, 9'd0, 1'b0, 13'h0000},
        '{3'd1, 6'd0,  9'd0, 1'b1, 13'h0001},
        '{3'd4, 6'd17, 9'd0, 1'b0, 13'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_valid = 1'b0;
    logic [5:0]  trap_code = '0;
    logic [8:0]  trap_sub = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_insn = '0;
    logic        trap_refill = 1'b0;
    logic [12:0] irq_lines = '0;
    logic        bus_fail_valid = 1'b0;
    logic        bus_fail_fetch = 1'b0;
    logic        mode_ld_valid = 1'b0;
    logic [1:0]  mode_ld_plv = '0;
    logic        mode_ld_ie = 1'b0;
    logic        mode_ld_pg = 1'b0;
    logic        mode_ld_dbg_exit = 1'b0;
    logic [2:0]  cfg_vs = '0;
    logic [31:0] cfg_eentry = EBASE;
    logic [31:0] cfg_refill_entry = RBASE;

    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  cur_plv, save_plv, rf_save_plv;
    logic        cur_ie, cur_da, cur_pg, save_ie, rf_save_ie, refill_busy;
    logic [5:0]  exc_code, dbg_code;
    logic [8:0]  exc_subcode;
    logic [31:0] era, rf_era, dbg_era, badv, badi;
    logic        dbg_dst, dbg_dcl, dbg_dei;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    exc_entry_seq dut (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_code(trap_code),
        .trap_sub(trap_sub), .trap_pc(trap_pc), .trap_insn(trap_insn),
        .trap_refill(trap_refill), .irq_lines(irq_lines),
        .bus_fail_valid(bus_fail_valid), .bus_fail_fetch(bus_fail_fetch),
        .mode_ld_valid(mode_ld_valid), .mode_ld_plv(mode_ld_plv),
        .mode_ld_ie(mode_ld_ie), .mode_ld_pg(mode_ld_pg),
        .mode_ld_dbg_exit(mode_ld_dbg_exit), .cfg_vs(cfg_vs),
        .cfg_eentry(cfg_eentry), .cfg_refill_entry(cfg_refill_entry),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cur_plv(cur_plv), .cur_ie(cur_ie), .cur_da(cur_da), .cur_pg(cur_pg),
        .save_plv(save_plv), .save_ie(save_ie), .rf_save_plv(rf_save_plv),
        .rf_save_ie(rf_save_ie), .refill_busy(refill_busy), .exc_code(exc_code),
        .exc_subcode(exc_subcode), .era(era), .rf_era(rf_era), .dbg_era(dbg_era),
        .badv(badv), .badi(badi), .dbg_dst(dbg_dst), .dbg_dcl(dbg_dcl),
        .dbg_dei(dbg_dei), .dbg_code(dbg_code)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_mode(input logic [1:0] plv, input logic ie, input logic pg, input logic dexit);
        mode_ld_valid = 1'b1; mode_ld_plv = plv; mode_ld_ie = ie;
        mode_ld_pg = pg; mode_ld_dbg_exit = dexit;
        step();
        mode_ld_valid = 1'b0; mode_ld_dbg_exit = 1'b0;
    endtask

    task automatic fire(input logic [5:0] code, input logic [8:0] sub, input logic refill,
                        input logic [12:0] lines, input logic [31:0] pc, input logic [31:0] insn);
        trap_valid = 1'b1; trap_code = code; trap_sub = sub; trap_refill = refill;
        irq_lines = lines; trap_pc = pc; trap_insn = insn;
        step();
        trap_valid = 1'b0; trap_refill = 1'b0;
    endtask

    function automatic logic [31:0] exp_target(input vec_t v);
        logic [31:0] vn;
        if (v.code == 6'd0) begin
            vn = 32'd64;
            for (int i = 0; i < 13; i++) if (v.lines[i]) vn = 32'd64 + i;
        end else if (v.refill) begin
            return RBASE;
        end else begin
            vn = {26'd0, v.code};
        end
        if (v.vs == 3'd0) return EBASE;
        return EBASE + vn * (32'd4 << v.vs);
    endfunction

    function automatic bit exp_badv(input logic [5:0] c);
        return (c >= 6'd11 && c <= 6'd18);
    endfunction

    function automatic bit exp_badi(input logic [5:0] c, input logic [8:0] s);
        return !(c == 6'd0 || c == 6'd3 || (c == 6'd8 && s == 9'd0));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pe_era, pe_badv, pe_badi, pe_code;
        logic [31:0] pc_i, in_i;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset values
        check("R1 redirect_pc", redirect_pc, 32'h1C00_0000);
        check("R1 plv/ie", {cur_plv, cur_ie}, 32'd0);
        check("R1 da/pg", {cur_da, cur_pg}, 32'd2);
        check("R1 busy/dst/valid", {refill_busy, dbg_dst, redirect_valid}, 32'd0);

        // R12 mode load
        load_mode(2'd3, 1'b1, 1'b1, 1'b0);
        check("R12 mode load", {cur_plv, cur_ie, cur_da, cur_pg}, {27'd0, 2'd3, 1'b1, 1'b0, 1'b1});

        for (int k = 0; k < NVEC; k++) begin
            load_mode(2'd3, 1'b1, 1'b1, 1'b1);
            pe_era = era; pe_badv = badv; pe_badi = badi; pe_code = {26'd0, exc_code};
            cfg_vs = TBL[k].vs;
            pc_i = 32'h0040_0000 + k * 32'h100;
            in_i = 32'hA500_0000 + k;
            fire(TBL[k].code, TBL[k].sub, TBL[k].refill, TBL[k].lines, pc_i, in_i);
            check("R2 redirect pulse", {31'd0, redirect_valid}, 32'd1);
            check("R2 plv/ie cleared", {cur_plv, cur_ie}, 32'd0);
            check("R5 R6 target", redirect_pc, exp_target(TBL[k]));
            if (TBL[k].refill && TBL[k].code != 6'd0) begin
                check("R4 refill save", {rf_save_plv, rf_save_ie}, 32'd7);
                check("R4 da/pg", {cur_da, cur_pg}, 32'd2);
                check("R4 rf_era", rf_era, pc_i >> 2);
                check("R4 era kept", era, pe_era);
                check("R4 code kept", {26'd0, exc_code}, pe_code);
                check("R4 busy", {31'd0, refill_busy}, 32'd1);
            end else begin
                check("R3 code", {17'd0, exc_code, exc_subcode}, {17'd0, TBL[k].code, TBL[k].sub});
                check("R3 saved mode", {save_plv, save_ie}, 32'd7);
                check("R3 era", era, pc_i);
            end
            check("R7 badv", badv, exp_badv(TBL[k].code) ? pc_i : pe_badv);
            check("R8 badi", badi, exp_badi(TBL[k].code, TBL[k].sub) ? in_i : pe_badi);
            step();
            check("R2 pulse ends", {31'd0, redirect_valid}, 32'd0);
        end

        // R12 load clears refill_busy
        load_mode(2'd1, 1'b0, 1'b0, 1'b0);
        check("R12 busy cleared", {30'd0, refill_busy, cur_da}, 32'd1);

        // R11 bus failure, fetch then memory
        cfg_vs = 3'd1;
        load_mode(2'd2, 1'b1, 1'b0, 1'b0);
        pe_badi = badi;
        trap_pc = 32'h0000_1230; trap_insn = 32'h1111_2222;
        bus_fail_valid = 1'b1; bus_fail_fetch = 1'b1;
        step();
        bus_fail_valid = 1'b0;
        check("R11 fetch code", {17'd0, exc_code, exc_subcode}, {17'd0, 6'd8, 9'd0});
        check("R11 fetch no badi", badi, pe_badi);
        check("R11 fetch target", redirect_pc, EBASE + 32'd8 * 32'd8);
        bus_fail_valid = 1'b1; bus_fail_fetch = 1'b0;
        step();
        bus_fail_valid = 1'b0;
        check("R11 mem code", {17'd0, exc_code, exc_subcode}, {17'd0, 6'd8, 9'd1});
        check("R11 mem badi", badi, 32'h1111_2222);
        // R11 trap has priority
        bus_fail_valid = 1'b1;
        fire(6'd12, 9'd0, 1'b0, 13'd0, 32'h0000_2000, 32'h3);
        bus_fail_valid = 1'b0;
        check("R11 trap priority", {26'd0, exc_code}, 32'd12);

        // R9 breakpoint
        load_mode(2'd3, 1'b1, 1'b1, 1'b1);
        pe_era = era;
        fire(6'd26, 9'd0, 1'b0, 13'd0, 32'h0000_5550, 32'hBEEF);
        check("R9 target", redirect_pc, EBASE + 32'h480);
        check("R9 flags", {dbg_dst, dbg_dcl, dbg_dei}, 32'd6);
        check("R9 dbg code", {26'd0, dbg_code}, 32'hC);
        check("R9 dbg_era", dbg_era, 32'h0000_5550);
        check("R9 era kept", era, pe_era);

        // R10 interrupt while in debug state
        pe_badi = badi; pe_code = {26'd0, exc_code};
        load_mode(2'd1, 1'b1, 1'b0, 1'b0);
        fire(6'd0, 9'd0, 1'b0, 13'h0004, 32'h0000_7770, 32'h0);
        check("R10 target", redirect_pc, EBASE + 32'h480);
        check("R10 dei", {31'd0, dbg_dei}, 32'd1);
        check("R10 dbg_era", dbg_era, 32'h0000_7770);
        check("R10 era kept", era, pe_era);
        check("R10 code kept", {26'd0, exc_code}, pe_code);
        check("R10 no badi", badi, pe_badi);

        // R12 debug exit clears flags
        load_mode(2'd0, 1'b0, 1'b0, 1'b1);
        check("R12 debug exit", {dbg_dst, dbg_dcl, dbg_dei}, 32'd0);

        // R12 trap wins over same-cycle load
        mode_ld_valid = 1'b1; mode_ld_plv = 2'd3; mode_ld_ie = 1'b1; mode_ld_pg = 1'b1;
        fire(6'd13, 9'd0, 1'b0, 13'd0, 32'h0000_9000, 32'h9);
        mode_ld_valid = 1'b0;
        check("R12 trap wins", {cur_plv, cur_ie, cur_pg}, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule